// File: doc/BRIEF.md
# Residual-Bit Shift-Add Multiplier

This block forms the exact product of a two's-complement multiplicand whose width is a narrow multiplier's width plus one to three extra bits, and a non-negative multiplier operand. Only the upper HI_W bits of the multiplicand reach a multiplier. The one to three low bits, the residual, are each used to gate a shifted copy of the second operand, and a short adder folds those copies into the shifted narrow product. The width of that multiplier therefore never grows to cover the extra bits.

Both operands are captured in an input register. The signed product is held in an output register. The FORM parameter selects one of two arrangements. The single form uses one HI_W-wide product of the whole second operand. The split form cuts the second operand into a high part and a low part, each at most one bit apart in width. It forms two narrower products and aligns them by shifting. The multiplicand width is HI_W+RES_W and the product width is HI_W+RES_W+B_W.

Top module: `resid_mul`

## Requirements
- R1: While `rst` is high at a rising edge, `product` reads zero after that edge. The input register is cleared as well, so at the first rising edge after `rst` falls `product` is still zero.
- R2: Operands present at rising edge k appear on `product` after rising edge k+1. `product` does not change while the operands are held.
- R3: `a` is taken as a two's-complement number of HI_W+RES_W bits and `b` as an unsigned number of B_W bits. `product` equals their exact product as a two's-complement value of HI_W+RES_W+B_W bits, including the most negative `a` and an all-ones `b`.
- R4: The residual is bits [RES_W-1:0] of `a`, read as unsigned. Each set bit k adds b·2^k to the result. When the residual is zero, `product` is (a >>> RES_W)·b·2^RES_W and its low RES_W bits are zero.
- R5: For every RES_W of 1, 2 and 3, the product is exact for every value of the residual.
- R6: With FORM = FORM_SPLIT, `b` is cut at bit B_W/2. The result is the same exact product as the single form, including when either part of `b` is zero and when B_W is odd.
- R7: When `a` is zero or `b` is zero, `product` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| a | input | HI_W+RES_W | Signed multiplicand, residual in the low RES_W bits |
| b | input | B_W | Unsigned multiplier operand |
| product | output | HI_W+RES_W+B_W | Registered signed product |

## Verification
The bench drives every residual value through instances built with one, two and three residual bits, with both positive and negative upper parts of the multiplicand. A tail that dropped the residual, shifted a copy by the wrong amount, or sign-extended the unsigned operand would give a wrong product for some of those values. The most negative multiplicand and an all-ones second operand expose a multiplier that treats the top bits as unsigned or truncates the sign. Split-form instances are driven with one part of `b` zero and with an odd B_W, which catches a wrong cut point or a wrong alignment shift. Holding the operands and then changing them, one edge at a time, catches a product that arrives one edge early or late, or one not cleared by reset.

// File: rtl/resid_mul_pkg.sv
package resid_mul_pkg;

    localparam int RES_W_MIN = 1;
    localparam int RES_W_MAX = 3;

    typedef enum logic {
        FORM_SINGLE = 1'b0,
        FORM_SPLIT  = 1'b1
    } form_e;

    function automatic int prod_width(input int hi_w, input int res_w, input int b_w);
        return hi_w + res_w + b_w;
    endfunction

    function automatic int low_part_width(input int b_w);
        return b_w / 2;
    endfunction

    function automatic int high_part_width(input int b_w);
        return b_w - (b_w / 2);
    endfunction

endpackage

// File: rtl/resid_mul_split.sv
module resid_mul_split #(
    parameter int HI_W  = 18,
    parameter int RES_W = 3
) (
    input  logic [HI_W+RES_W-1:0] a_in,
    output logic signed [HI_W-1:0] a_hi,
    output logic [RES_W-1:0]       a_lo
);
    localparam int AW = HI_W + RES_W;

    // upper part keeps the sign, residual is plain magnitude
    always_comb begin
        a_hi = $signed(a_in[AW-1:RES_W]);
        a_lo = a_in[RES_W-1:0];
    end
endmodule

// File: rtl/resid_mul_core.sv
module resid_mul_core
    import resid_mul_pkg::*;
#(
    parameter int    HI_W  = 18,
    parameter int    RES_W = 3,
    parameter int    B_W   = 34,
    parameter form_e FORM  = FORM_SINGLE
) (
    input  logic signed [HI_W-1:0]            a_hi,
    input  logic [B_W-1:0]                    b_in,
    output logic signed [HI_W+RES_W+B_W-1:0]  hi_term
);
    localparam int PW  = prod_width(HI_W, RES_W, B_W);
    localparam int LOW = low_part_width(B_W);
    localparam int HIG = high_part_width(B_W);

    logic signed [PW-1:0] ah_x;
    assign ah_x = {{(PW-HI_W){a_hi[HI_W-1]}}, a_hi};

    generate
        if (FORM == FORM_SINGLE) begin : g_single
            logic signed [PW-1:0] b_x;
            logic signed [PW-1:0] whole;
            always_comb begin
                b_x     = {{(PW-B_W){1'b0}}, b_in};
                whole   = ah_x * b_x;
                hi_term = whole <<< RES_W;
            end
        end else begin : g_split
            logic signed [PW-1:0] bh_x;
            logic signed [PW-1:0] bl_x;
            logic signed [PW-1:0] part_h;
            logic signed [PW-1:0] part_l;
            always_comb begin
                bh_x    = {{(PW-HIG){1'b0}}, b_in[B_W-1:LOW]};
                bl_x    = {{(PW-LOW){1'b0}}, b_in[LOW-1:0]};
                part_h  = ah_x * bh_x;
                part_l  = ah_x * bl_x;
                hi_term = (part_h <<< (RES_W + LOW)) + (part_l <<< RES_W);
            end
        end
    endgenerate
endmodule

// File: rtl/resid_mul_tail.sv
module resid_mul_tail #(
    parameter int RES_W = 3,
    parameter int B_W   = 34,
    parameter int PW    = 55
) (
    input  logic [RES_W-1:0] a_lo,
    input  logic [B_W-1:0]   b_in,
    output logic [PW-1:0]    tail
);
    logic [PW-1:0] b_x;
    logic [PW-1:0] gated [RES_W];

    assign b_x = {{(PW-B_W){1'b0}}, b_in};

    genvar k;
    generate
        for (k = 0; k < RES_W; k++) begin : g_copy
            assign gated[k] = {PW{a_lo[k]}} & (b_x << k);
        end
    endgenerate

    always_comb begin
        tail = '0;
        for (int i = 0; i < RES_W; i++) begin
            tail = tail + gated[i];
        end
    end
endmodule

// File: rtl/resid_mul.sv
module resid_mul
    import resid_mul_pkg::*;
#(
    parameter int    HI_W  = 18,
    parameter int    RES_W = 3,
    parameter int    B_W   = 34,
    parameter form_e FORM  = FORM_SINGLE
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic [HI_W+RES_W-1:0]              a,
    input  logic [B_W-1:0]                     b,
    output logic signed [HI_W+RES_W+B_W-1:0]   product
);
    localparam int AW = HI_W + RES_W;
    localparam int PW = prod_width(HI_W, RES_W, B_W);

    typedef struct packed {
        logic [AW-1:0]  mcand;
        logic [B_W-1:0] mplier;
    } opnd_t;

    opnd_t opnd_q;

    logic signed [HI_W-1:0] a_hi;
    logic [RES_W-1:0]       a_lo;
    logic signed [PW-1:0]   hi_term;
    logic [PW-1:0]          tail;
    logic signed [PW-1:0]   sum;

    always_ff @(posedge clk) begin
        if (rst) begin
            opnd_q <= '0;
        end else begin
            opnd_q.mcand  <= a;
            opnd_q.mplier <= b;
        end
    end

    resid_mul_split #(
        .HI_W  (HI_W),
        .RES_W (RES_W)
    ) u_split (
        .a_in (opnd_q.mcand),
        .a_hi (a_hi),
        .a_lo (a_lo)
    );

    resid_mul_core #(
        .HI_W  (HI_W),
        .RES_W (RES_W),
        .B_W   (B_W),
        .FORM  (FORM)
    ) u_core (
        .a_hi    (a_hi),
        .b_in    (opnd_q.mplier),
        .hi_term (hi_term)
    );

    resid_mul_tail #(
        .RES_W (RES_W),
        .B_W   (B_W),
        .PW    (PW)
    ) u_tail (
        .a_lo (a_lo),
        .b_in (opnd_q.mplier),
        .tail (tail)
    );

    // tail < 2^(B_W+RES_W), so it is always a positive PW-bit value
    assign sum = hi_term + $signed(tail);

    always_ff @(posedge clk) begin
        if (rst) begin
            product <= '0;
        end else begin
            product <= sum;
        end
    end
endmodule

// File: rtl/resid_mul_chk.sv
module resid_mul_chk #(
    parameter int HI_W  = 18,
    parameter int RES_W = 3,
    parameter int B_W   = 34
) (
    input logic                              clk,
    input logic                              rst,
    input logic [HI_W+RES_W-1:0]             a,
    input logic [B_W-1:0]                    b,
    input logic signed [HI_W+RES_W+B_W-1:0]  product
);
    localparam int AW = HI_W + RES_W;
    localparam int PW = AW + B_W;

    logic [1:0]           warm;
    logic [AW-1:0]        a_d1, a_d2;
    logic [B_W-1:0]       b_d1, b_d2;
    logic signed [PW-1:0] ref_a, ref_b, ref_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            warm <= 2'd0;
        end else if (warm != 2'd3) begin
            warm <= warm + 2'd1;
        end
        a_d1 <= a;
        a_d2 <= a_d1;
        b_d1 <= b;
        b_d2 <= b_d1;
    end

    always_comb begin
        ref_a = {{B_W{a_d2[AW-1]}}, a_d2};
        ref_b = {{AW{1'b0}}, b_d2};
        ref_p = ref_a * ref_b;
    end

    // R1
    rst_clears_chk: assert property (@(posedge clk) rst |=> product == '0);

    // R3
    exact_product_chk: assert property (@(posedge clk) disable iff (rst)
        (warm >= 2'd2) |-> product == ref_p);

    // R2
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (warm >= 2'd2 && a_d1 == a_d2 && b_d1 == b_d2) |=> $stable(product));

    // R4
    residual_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (warm >= 2'd2 && a_d2[RES_W-1:0] == '0) |-> product[RES_W-1:0] == '0);

    // R7
    zero_operand_chk: assert property (@(posedge clk) disable iff (rst)
        (warm >= 2'd2 && (a_d2 == '0 || b_d2 == '0)) |-> product == '0);
endmodule

bind resid_mul resid_mul_chk #(
    .HI_W  (HI_W),
    .RES_W (RES_W),
    .B_W   (B_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .a       (a),
    .b       (b),
    .product (product)
);

// File: tb/resid_mul_tb.sv
module resid_mul_tb;
    import resid_mul_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // u_dut: 18+3 x 34 single; u_r1: 8+1 x 12 single; u_r2: 8+2 x 12 split; u_r3s: 8+3 x 11 split
    logic [20:0] a0; logic [33:0] b0; logic signed [54:0] p0;
    logic [8:0]  a1; logic [11:0] b1; logic signed [20:0] p1;
    logic [9:0]  a2; logic [11:0] b2; logic signed [21:0] p2;
    logic [10:0] a3; logic [10:0] b3; logic signed [21:0] p3;

    resid_mul #(.HI_W(18), .RES_W(3), .B_W(34), .FORM(FORM_SINGLE)) u_dut
        (.clk(clk), .rst(rst), .a(a0), .b(b0), .product(p0));
    resid_mul #(.HI_W(8), .RES_W(1), .B_W(12), .FORM(FORM_SINGLE)) u_r1
        (.clk(clk), .rst(rst), .a(a1), .b(b1), .product(p1));
    resid_mul #(.HI_W(8), .RES_W(2), .B_W(12), .FORM(FORM_SPLIT)) u_r2
        (.clk(clk), .rst(rst), .a(a2), .b(b2), .product(p2));
    resid_mul #(.HI_W(8), .RES_W(3), .B_W(11), .FORM(FORM_SPLIT)) u_r3s
        (.clk(clk), .rst(rst), .a(a3), .b(b3), .product(p3));

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic longint ref0();
        return longint'($signed(a0)) * longint'(b0);
    endfunction
    function automatic longint ref1();
        return longint'($signed(a1)) * longint'(b1);
    endfunction
    function automatic longint ref2();
        return longint'($signed(a2)) * longint'(b2);
    endfunction
    function automatic longint ref3();
        return longint'($signed(a3)) * longint'(b3);
    endfunction

    task automatic check_all(input string req);
        chk(req, "u_dut", longint'(p0), ref0());
        chk(req, "u_r1",  longint'(p1), ref1());
        chk(req, "u_r2",  longint'(p2), ref2());
        chk(req, "u_r3s", longint'(p3), ref3());
    endtask

    // upper part ah (signed), residual al, multiplier bv into every instance
    task automatic set_ops(input longint ah, input int al, input longint bv);
        a0 = {18'(ah), 3'(al)};
        a1 = {8'(ah),  1'(al)};
        a2 = {8'(ah),  2'(al)};
        a3 = {8'(ah),  3'(al)};
        b0 = 34'(bv); b1 = 12'(bv); b2 = 12'(bv); b3 = 11'(bv);
    endtask

    task automatic settle();
        @(posedge clk); @(posedge clk); @(negedge clk);
    endtask

    task automatic t_reset();
        set_ops(-5, 3, 1000);
        repeat (3) @(negedge clk);
        chk("R1", "during reset", longint'(p0), 0);
        chk("R1", "during reset r1", longint'(p1), 0);
        rst = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R1", "first edge after reset", longint'(p0), 0);
        chk("R1", "first edge after reset r2", longint'(p2), 0);
        @(posedge clk); @(negedge clk);
        check_all("R1");
    endtask

    task automatic t_latency();
        longint first0, first3;
        set_ops(37, 1, 555);
        settle();
        check_all("R2");
        first0 = ref0(); first3 = ref3();
        set_ops(-90, 2, 1234);
        @(posedge clk); @(negedge clk);
        chk("R2", "one edge after change", longint'(p0), first0);
        chk("R2", "one edge after change r3s", longint'(p3), first3);
        @(posedge clk); @(negedge clk);
        check_all("R2");
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check_all("R2");
        end
    endtask

    task automatic t_residual_sweep();
        longint ahs[4] = '{-77, 45, -1, 0};
        longint bvs[2] = '{2047, 1365};
        foreach (ahs[i]) begin
            foreach (bvs[j]) begin
                for (int al = 0; al < 8; al++) begin
                    @(negedge clk);
                    set_ops(ahs[i], al, bvs[j]);
                    settle();
                    check_all("R5");
                    if (al == 0) begin
                        chk("R4", "low bits u_dut", longint'(p0[2:0]), 0);
                        chk("R4", "low bits u_r1", longint'(p1[0]), 0);
                        chk("R4", "low bits u_r3s", longint'(p3[2:0]), 0);
                    end else begin
                        check_all("R4");
                    end
                end
            end
        end
    endtask

    task automatic t_corners();
        @(negedge clk);
        a0 = 21'h100000; b0 = '1; a1 = 9'h100; b1 = '1;
        a2 = 10'h200; b2 = '1; a3 = 11'h400; b3 = '1;
        settle(); check_all("R3");
        a0 = 21'h0FFFFF; a1 = 9'h0FF; a2 = 10'h1FF; a3 = 11'h3FF;
        settle(); check_all("R3");
        a0 = '1; a1 = '1; a2 = '1; a3 = '1;
        settle(); check_all("R3");
        b0 = 34'd1; b1 = 12'd1; b2 = 12'd1; b3 = 11'd1;
        settle(); check_all("R3");
    endtask

    task automatic t_zero();
        @(negedge clk);
        a0 = '0; a1 = '0; a2 = '0; a3 = '0;
        b0 = '1; b1 = '1; b2 = '1; b3 = '1;
        settle();
        chk("R7", "a zero", longint'(p0), 0);
        chk("R7", "a zero r2", longint'(p2), 0);
        a0 = 21'h100000; a1 = 9'h100; a2 = 10'h200; a3 = 11'h400;
        b0 = '0; b1 = '0; b2 = '0; b3 = '0;
        settle();
        chk("R7", "b zero", longint'(p0), 0);
        chk("R7", "b zero r3s", longint'(p3), 0);
    endtask

    task automatic t_split();
        // low part zero, high part zero, all ones, alternating; split cut at B_W/2
        longint pats[4] = '{longint'(12'hFC0), longint'(12'h03F), longint'(12'hFFF), longint'(12'hA5A)};
        foreach (pats[i]) begin
            @(negedge clk);
            set_ops(-113, 5, pats[i]);
            b3 = (i == 0) ? 11'h7E0 : (i == 1) ? 11'h01F : 11'(pats[i]);
            settle();
            chk("R6", "split r2", longint'(p2), ref2());
            chk("R6", "split odd r3s", longint'(p3), ref3());
        end
    endtask

    task automatic t_random();
        for (int n = 0; n < 300; n++) begin
            @(negedge clk);
            a0 = 21'($urandom); b0 = {2'($urandom), 32'($urandom)};
            a1 = 9'($urandom);  b1 = 12'($urandom);
            a2 = 10'($urandom); b2 = 12'($urandom);
            a3 = 11'($urandom); b3 = 11'($urandom);
            settle();
            check_all("R3");
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        t_reset();
        t_latency();
        t_residual_sweep();
        t_corners();
        t_zero();
        t_split();
        t_random();
        finish_run();
    end
endmodule